// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block keeps a running cyclic redundancy check over data words that arrive back to back. Words come from one of two sources. One is a register-style write port that a processor uses. The other is a valid/ready stream that a DMA engine would drive. Either source can supply a new word every clock, and each accepted word is folded into the running checksum in the same clock in which it is accepted.

A mode register selects one of three fixed generator polynomials. It also holds four independent conditioning switches: bit reversal and one's complement of each incoming word, and bit reversal and one's complement of the result shown on the sum output. A seed register supplies the starting value. Writing the seed, or changing the mode, restarts the running checksum from the seed, so a checksum is never computed partly under one polynomial and partly under another. Each word may be 8, 16 or 32 bits wide.

The processor port has three registers: mode at address 0, seed at address 1 and data at address 2. Address 3 decodes to nothing.

Top module: `crc_engine`

## Requirements
- R1: Mode poly field (mode bits [1:0]) = 0 selects the 16-bit polynomial 0x1021 (x^16+x^12+x^5+1). Bits are folded most significant first, with no final XOR unless requested.
- R2: Poly field = 1 selects the 16-bit polynomial 0x8005 (x^16+x^15+x^2+1).
- R3: Poly field = 2 or 3 selects the 32-bit polynomial 0x04C11DB7.
- R4: Each accepted data word folds 8, 16 or 32 bits in one clock, chosen by a size code of 0, 1 or 2; code 3 also means 32 bits. Only the low bits of the word are used, and no register changes in a cycle with no write and no stream transfer.
- R5: Mode bit 2 reverses the bit order of each incoming word within its size, so the least significant bit is folded first.
- R6: Mode bit 3 folds the one's complement of each incoming word, within its size.
- R7: Mode bit 4 reverses the sum output within the active CRC width. Mode bit 5 complements it within that width. Neither switch alters the running state.
- R8: A write to address 1 stores the seed and loads the running CRC from it at the next clock.
- R9: A write to address 0 stores mode bits [5:0] and reloads the running CRC from the stored seed, sized to the new polynomial.
- R10: For the two 16-bit polynomials, only the low 16 bits of the seed are used, and sum bits [31:16] read as zero.
- R11: The stream is accepted on every clock in which the processor port is idle, so consecutive words fold without gaps. A processor write of any kind takes that clock, holds s_ready low, and the stream word is not folded.
- R12: After reset the mode is 0, the seed and the running CRC are 0, and s_ready is high. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 2 | Register select: 0 mode, 1 seed, 2 data |
| cpu_wdata | input | 32 | Processor write data |
| cpu_size | input | 2 | Size of a data write: 0 byte, 1 half, 2 or 3 word |
| s_valid | input | 1 | Stream word present |
| s_ready | output | 1 | Stream word accepted this clock |
| s_data | input | 32 | Stream word |
| s_size | input | 2 | Size of the stream word, same coding as cpu_size |
| crc_sum | output | 32 | Conditioned running checksum |

## Verification
The bench runs the classic nine-byte check string under each polynomial with the known catalogue results. An engine with a wrong tap, or with the fold running from the wrong end, misses those constants at once. Byte, halfword and word writes are compared with a bit-serial model. A design that folded the wrong number of bits, or that reversed across the full 32 bits instead of within the size, drifts from that model. Further tests cover the seed truncation in 16-bit modes, the reload when the mode is written, a gapless stream, and a stream word that collides with a processor write. The last one exposes a design that folds the colliding word or that drops a beat of the stream.

// File: rtl/crc_eng_pkg.sv
// Shared types for the CRC engine: the mode register layout, the register
// addresses and the polynomial lookup. Assumes all data paths are 32 bits.
package crc_eng_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NARROW_W = 16;
    localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        POLY_CCITT = 2'd0,
        POLY_ARC16 = 2'd1,
        POLY_ETH32 = 2'd2,
        POLY_ETH32B = 2'd3
    } poly_e;

    typedef struct packed {
        logic  out_inv;
        logic  out_rev;
        logic  in_inv;
        logic  in_rev;
        poly_e poly;
    } mode_t;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_SEED = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_e;

    // Generator taps (implicit top bit dropped) for a selector value.
    function automatic logic [WORD_W-1:0] poly_taps(input poly_e p);
        case (p)
            POLY_CCITT: return 32'h0000_1021;
            POLY_ARC16: return 32'h0000_8005;
            default:    return 32'h04C1_1DB7;
        endcase
    endfunction

    // True when the selected polynomial is 32 bits wide.
    function automatic logic poly_wide(input poly_e p);
        return p[1];
    endfunction
endpackage

// File: rtl/crc_in_cond.sv
// Input conditioning: sizes the incoming word and optionally reverses and/or
// complements it within its size. Output is right-aligned so the first bit to
// fold sits at position nbits-1. Assumes size code 3 behaves as 32 bits.
module crc_in_cond
    import crc_eng_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  logic [1:0]        size,
    input  logic              rev,
    input  logic              inv,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  nbits
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] r8, r16, r32, picked;

    // Build the three reversed variants of the word.
    always_comb begin
        r8 = '0;
        r16 = '0;
        for (int i = 0; i < 8; i++) r8[i] = data[7-i];
        for (int i = 0; i < 16; i++) r16[i] = data[15-i];
        for (int i = 0; i < 32; i++) r32[i] = data[31-i];
    end

    // Select the width, reversal and complement for this word.
    always_comb begin
        case (size)
            2'd0:    begin mask = 32'h0000_00FF; nbits = CNT_W'(8);  picked = rev ? r8  : data; end
            2'd1:    begin mask = 32'h0000_FFFF; nbits = CNT_W'(16); picked = rev ? r16 : data; end
            default: begin mask = 32'hFFFF_FFFF; nbits = CNT_W'(32); picked = rev ? r32 : data; end
        endcase
        word = (picked ^ (inv ? mask : '0)) & mask;
    end
endmodule

// File: rtl/crc_fold.sv
// Combinational fold of up to WORD_W bits into a CRC state, most significant
// bit of the sized word first. One generated stage per bit; stages beyond
// nbits pass the state through. Assumes crc_in upper half is zero when narrow.
module crc_fold
    import crc_eng_pkg::*;
(
    input  logic [WORD_W-1:0] crc_in,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [WORD_W-1:0] taps,
    input  logic              wide,
    output logic [WORD_W-1:0] crc_out
);
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_stage
        logic [WORD_W-1:0] prev, nxt, q;
        logic [4:0] pos;
        logic fb;
        if (gi == 0) begin : g_first
            assign prev = crc_in;
        end else begin : g_rest
            assign prev = g_stage[gi-1].q;
        end
        // One LFSR shift for the bit at position nbits-1-gi.
        always_comb begin
            pos = 5'(nbits - CNT_W'(gi + 1));
            fb  = (wide ? prev[WORD_W-1] : prev[NARROW_W-1]) ^ word[pos];
            nxt = {prev[WORD_W-2:0], 1'b0} ^ (fb ? taps : '0);
            if (!wide) nxt[WORD_W-1:NARROW_W] = '0;
            q = (CNT_W'(gi) < nbits) ? nxt : prev;
        end
    end
    assign crc_out = g_stage[WORD_W-1].q;
endmodule

// File: rtl/crc_out_cond.sv
// Output conditioning: optional reversal and complement of the running CRC
// within its active width. Assumes upper bits of crc are zero when narrow.
module crc_out_cond
    import crc_eng_pkg::*;
(
    input  logic [WORD_W-1:0] crc,
    input  logic              wide,
    input  logic              rev,
    input  logic              inv,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] r16, r32, mask;

    // Reverse and complement within 16 or 32 bits.
    always_comb begin
        r16 = '0;
        for (int i = 0; i < 16; i++) r16[i] = crc[15-i];
        for (int i = 0; i < 32; i++) r32[i] = crc[31-i];
        mask = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        sum  = ((rev ? (wide ? r32 : r16) : crc) ^ (inv ? mask : '0)) & mask;
    end
endmodule

// File: rtl/crc_engine.sv
// CRC engine top: mode, seed and running CRC registers, a processor write
// port and a DMA-style stream. A processor write owns its clock; otherwise
// one stream word is folded per clock. Assumes the stream holds its word
// while s_ready is low.
module crc_engine
    import crc_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [1:0]        cpu_size,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    input  logic [1:0]        s_size,
    output logic [WORD_W-1:0] crc_sum
);
    mode_t             mode_q, mode_new;
    logic [WORD_W-1:0] seed_q, crc_q, fold_res;
    logic [WORD_W-1:0] src_data, cond_word;
    logic [1:0]        src_size;
    logic [CNT_W-1:0]  cond_bits;
    logic              wide, take_stream;

    assign wide        = poly_wide(mode_q.poly);
    assign s_ready     = !cpu_we;
    assign take_stream = s_valid && s_ready;
    assign mode_new    = mode_t'(cpu_wdata[5:0]);

    // Pick the word to fold: processor data write or stream word.
    always_comb begin
        src_data = cpu_we ? cpu_wdata : s_data;
        src_size = cpu_we ? cpu_size  : s_size;
    end

    crc_in_cond u_in (
        .data(src_data), .size(src_size), .rev(mode_q.in_rev), .inv(mode_q.in_inv),
        .word(cond_word), .nbits(cond_bits)
    );

    crc_fold u_fold (
        .crc_in(crc_q), .word(cond_word), .nbits(cond_bits),
        .taps(poly_taps(mode_q.poly)), .wide(wide), .crc_out(fold_res)
    );

    crc_out_cond u_out (
        .crc(crc_q), .wide(wide), .rev(mode_q.out_rev), .inv(mode_q.out_inv), .sum(crc_sum)
    );

    // Register updates: reset, register writes, then stream folds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            seed_q <= '0;
            crc_q  <= '0;
        end else if (cpu_we) begin
            case (reg_e'(cpu_addr))
                REG_MODE: begin
                    mode_q <= mode_new;
                    crc_q  <= poly_wide(mode_new.poly) ? seed_q : {16'h0, seed_q[15:0]};
                end
                REG_SEED: begin
                    seed_q <= cpu_wdata;
                    crc_q  <= wide ? cpu_wdata : {16'h0, cpu_wdata[15:0]};
                end
                REG_DATA: crc_q <= fold_res;
                default:  ;
            endcase
        end else if (take_stream) begin
            crc_q <= fold_res;
        end
    end

    // R8: a seed write loads the running CRC, sized to the current width.
    assert_seed_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 2'd1) |=>
            crc_q == (wide ? $past(cpu_wdata) : {16'h0, $past(cpu_wdata[15:0])}));

    // R9: a mode write reloads the running CRC from the stored seed.
    assert_mode_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 2'd0) |=>
            crc_q == (wide ? seed_q : {16'h0, seed_q[15:0]}));

    // R10: narrow polynomials keep the upper sum bits at zero.
    assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> crc_sum[31:16] == 16'h0);

    // R4: with no write and no stream word, state holds.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we && !s_valid) |=> ($stable(crc_q) && $stable(seed_q) && $stable(mode_q)));

    // R11: a stream word colliding with a processor write leaves the CRC untouched
    // unless the write itself targets a register that changes it.
    assert_collide_no_fold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 2'd3 && s_valid) |=> $stable(crc_q));
endmodule

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_we = 0;
    logic [1:0]  cpu_addr = 0;
    logic [31:0] cpu_wdata = 0;
    logic [1:0]  cpu_size = 0;
    logic        s_valid = 0;
    logic        s_ready;
    logic [31:0] s_data = 0;
    logic [1:0]  s_size = 0;
    logic [31:0] crc_sum;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    crc_engine dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_size(cpu_size), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .s_size(s_size), .crc_sum(crc_sum)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Bit-serial reference fold built from the requirements.
    function automatic logic [31:0] m_fold(input logic [31:0] crc, input logic [31:0] d,
                                           input logic [1:0] sz, input logic [5:0] md);
        int n;
        logic wide, b, top;
        logic [31:0] p, c;
        int src;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        wide = md[1];
        p = md[1] ? 32'h04C11DB7 : (md[0] ? 32'h8005 : 32'h1021);
        c = crc;
        for (int k = 0; k < n; k++) begin
            src = md[2] ? k : n - 1 - k;
            b = d[src] ^ md[3];
            top = wide ? c[31] : c[15];
            c = {c[30:0], 1'b0};
            if (top ^ b) c = c ^ p;
            if (!wide) c[31:16] = 16'h0;
        end
        return c;
    endfunction

    function automatic logic [31:0] m_out(input logic [31:0] c, input logic [5:0] md);
        int w;
        logic [31:0] r;
        w = md[1] ? 32 : 16;
        r = c;
        if (md[4]) begin
            r = '0;
            for (int i = 0; i < w; i++) r[i] = c[w-1-i];
        end
        if (md[5]) r = r ^ (md[1] ? 32'hFFFFFFFF : 32'h0000FFFF);
        return r;
    endfunction

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_size = sz;
        @(negedge clk);
        cpu_we = 0;
    endtask

    task automatic setup(input logic [5:0] md, input logic [31:0] seed);
        cpu_write(2'd0, {26'h0, md}, 2'd0);
        cpu_write(2'd1, seed, 2'd0);
    endtask

    task automatic feed_check_string;
        for (int i = 0; i < 9; i++) cpu_write(2'd2, 32'h31 + i, 2'd0);
    endtask

    task automatic t_reset;
        check("R12 reset sum", crc_sum, 32'h0);
        check("R12 reset s_ready", {31'h0, s_ready}, 32'h1);
    endtask

    task automatic t_ccitt;
        setup(6'h00, 32'hFFFF);
        feed_check_string();
        check("R1 ccitt check string", crc_sum, 32'h29B1);
    endtask

    task automatic t_arc16;
        setup(6'h15, 32'h0);
        feed_check_string();
        check("R2 R5 R7 crc16 reflected check string", crc_sum, 32'hBB3D);
    endtask

    task automatic t_eth32;
        setup(6'h02, 32'hFFFFFFFF);
        feed_check_string();
        check("R3 crc32 plain check string", crc_sum, 32'h0376E6E7);
        setup(6'h36, 32'hFFFFFFFF);
        feed_check_string();
        check("R3 R7 crc32 reflected inverted check string", crc_sum, 32'hCBF43926);
        setup(6'h03, 32'hFFFFFFFF);
        feed_check_string();
        check("R3 poly code 3 as 32-bit", crc_sum, 32'h0376E6E7);
    endtask

    task automatic t_sizes;
        logic [31:0] e;
        setup(6'h02, 32'hFFFFFFFF);
        cpu_write(2'd2, 32'hDEADBEEF, 2'd2);
        e = m_fold(32'hFFFFFFFF, 32'hDEADBEEF, 2'd2, 6'h02);
        check("R4 32-bit write", crc_sum, e);
        cpu_write(2'd2, 32'h1234ABCD, 2'd1);
        e = m_fold(e, 32'h0000ABCD, 2'd1, 6'h02);
        check("R4 16-bit write uses low half", crc_sum, e);
        cpu_write(2'd2, 32'hFFFFFF5A, 2'd0);
        e = m_fold(e, 32'h5A, 2'd0, 6'h02);
        check("R4 8-bit write uses low byte", crc_sum, e);
        cpu_write(2'd2, 32'h0BADF00D, 2'd3);
        e = m_fold(e, 32'h0BADF00D, 2'd2, 6'h02);
        check("R4 size code 3 as word", crc_sum, e);
    endtask

    task automatic t_in_cond;
        logic [31:0] e;
        setup(6'h06, 32'h0);
        cpu_write(2'd2, 32'h00001234, 2'd1);
        e = m_fold(32'h0, 32'h2C48, 2'd1, 6'h02);
        check("R5 reversal within 16 bits", crc_sum, e);
        setup(6'h08, 32'hFFFF);
        cpu_write(2'd2, 32'h000000C3, 2'd0);
        e = m_fold(32'hFFFF, 32'h3C, 2'd0, 6'h00);
        check("R6 complement within a byte", crc_sum, e);
    endtask

    task automatic t_out_cond;
        logic [31:0] c;
        setup(6'h32, 32'h0);
        cpu_write(2'd2, 32'hCAFEF00D, 2'd2);
        c = m_fold(32'h0, 32'hCAFEF00D, 2'd2, 6'h32);
        check("R7 out reverse and complement 32", crc_sum, m_out(c, 6'h32));
        cpu_write(2'd2, 32'h77, 2'd0);
        c = m_fold(c, 32'h77, 2'd0, 6'h32);
        check("R7 running state unaffected by output switches", crc_sum, m_out(c, 6'h32));
    endtask

    task automatic t_seed_mode;
        setup(6'h00, 32'hABCD1234);
        check("R8 R10 narrow seed load", crc_sum, 32'h00001234);
        cpu_write(2'd0, 32'h02, 2'd0);
        check("R9 mode write reloads full seed", crc_sum, 32'hABCD1234);
        cpu_write(2'd2, 32'h55, 2'd0);
        cpu_write(2'd0, 32'h20, 2'd0);
        check("R9 R10 reload to narrow with out complement", crc_sum, 32'h0000EDCB);
    endtask

    task automatic t_stream;
        logic [31:0] e;
        int stalls = 0;
        setup(6'h02, 32'hFFFFFFFF);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i > 0 && !s_ready) stalls++;
            s_valid = 1; s_data = 32'h31 + i; s_size = 2'd0;
        end
        @(negedge clk);
        s_valid = 0;
        check("R11 stream gapless, no stalls", stalls, 0);
        check("R11 stream check string", crc_sum, 32'h0376E6E7);
        e = crc_sum;
        @(negedge clk);
        s_valid = 1; s_data = 32'h99; s_size = 2'd0;
        cpu_we = 1; cpu_addr = 2'd3; cpu_wdata = 32'h0;
        #1;
        check("R11 s_ready low during cpu write", {31'h0, s_ready}, 32'h0);
        @(negedge clk);
        cpu_we = 0; s_valid = 0;
        check("R11 R12 colliding word not folded, addr 3 ignored", crc_sum, e);
        @(negedge clk);
        s_valid = 1; s_data = 32'h99; cpu_we = 1; cpu_addr = 2'd1; cpu_wdata = 32'h12345678;
        @(negedge clk);
        cpu_we = 0;
        check("R11 seed write wins over stream", crc_sum, 32'h12345678);
        @(negedge clk);
        s_valid = 0;
        check("R11 held word folds after write", crc_sum, m_fold(32'h12345678, 32'h99, 2'd0, 6'h02));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ccitt();
        t_arc16();
        t_eth32();
        t_sizes();
        t_in_cond();
        t_out_cond();
        t_seed_mode();
        t_stream();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule